// File: doc/BRIEF.md
# Synthesizer Divider Serial Load Port

This block is the programming front end of a fractional-N frequency synthesizer. It takes a three-wire serial stream made of a serial clock, a serial data line and an active-low load window. It assembles the bits into one of two targets, and the register-select input picks which one. The first target is a 20-bit staging word. Its contents reach the divider outputs only when it is committed into an active word, so a whole new divider setting takes effect at once. A commit is triggered by the rising edge of the load window or by the rising edge of a separate hop strobe. The second target is an 8-bit enhancement word, which changes bit by bit as data arrives.

All serial inputs are sampled in the system clock domain through two-flop synchronizers, and edges are found by comparison with the previous sample. The system clock must run at least four times faster than the serial clock. A mode input chooses what drives the registered divider outputs: either fields of the active word, or parallel pins for the M, A and K values. A prescaler enable passes through with one clock of delay.

A small state machine sequences commits. It has three states. XS_IDLE means the load window is closed. XS_LOADING means the load window is open. XS_XFER is the commit cycle. The transitions are:
- IDLE→LOADING when the window opens.
- IDLE/LOADING→XFER on a load-window or hop rising edge.
- XFER→XFER on another such edge.
- XFER→LOADING when the window is open.
- XFER→IDLE otherwise.

Top module: `synth_serial_port`

## Requirements
- R1: After reset the active word, the enhancement word and all divider outputs are zero.
- R2: Serial clock edges that occur while `load_n` is high change neither target. Later commits and `enh_q` show no effect from them.
- R3: With `enh_sel` low, each serial clock rising edge inside the load window shifts `ser_data` into the staging word MSB first. Only the last 20 bits are kept. In serial mode (`direct_sel` low) the outputs are taken from the active word: `div_m` = bits 19:11, `div_a` = bits 10:7, and `div_k` = bits 6:0 zero-extended to 18 bits.
- R4: With `enh_sel` high, bits shift MSB first into the 8-bit enhancement word. `enh_q` reflects every bit with no commit step, and the staging word is left untouched.
- R5: Bits in the staging word do not reach the divider outputs before a commit.
- R6: A rising edge of `hop_wr` commits the staging word while the load window stays open.
- R7: With `direct_sel` high, `div_k`, `div_m` and `div_a` equal the parallel inputs sampled at the previous system clock edge. Returning `direct_sel` low restores the active-word fields.
- R8: `presc_en_n_o` equals `presc_en_n_i` delayed by one system clock. A high level means the prescaler is bypassed.
- R9: Commits happen on strobe edges, not levels. With `hop_wr` held high, newly shifted bits stay off the outputs until `hop_wr` rises again. The active word changes only in a commit cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial clock, bits captured on its rising edge |
| ser_data | input | 1 | Serial data, MSB first |
| load_n | input | 1 | Load window, active low; rising edge commits |
| enh_sel | input | 1 | High: target is the enhancement word |
| hop_wr | input | 1 | Commit strobe, rising edge |
| direct_sel | input | 1 | High: divider outputs from parallel pins |
| par_k | input | 18 | Parallel K value |
| par_m | input | 9 | Parallel M value |
| par_a | input | 4 | Parallel A value |
| presc_en_n_i | input | 1 | Prescaler enable, active low |
| div_k | output | 18 | K divider value |
| div_m | output | 9 | M divider value |
| div_a | output | 4 | A divider value |
| enh_q | output | 8 | Enhancement word |
| presc_en_n_o | output | 1 | Registered prescaler enable |

## Verification
The bench builds the block with its default widths: a 20-bit staging word, an 8-bit enhancement word and 18/9/4-bit K/M/A fields. At these widths every field boundary of the serial mapping falls inside a single random word, so an off-by-one in a field split shows up in the outputs. The serial clock period is eight system clocks, twice the minimum ratio, which leaves the synchronizer latency visible without hiding misordered bits. Over-long frames, clocking with the load window closed, a hop strobe held high and mode switching are exercised as directed cases between the random frames.

// File: rtl/synth_spi_pkg.sv
package synth_spi_pkg;
    localparam int PRI_W = 20;
    localparam int ENH_W = 8;
    localparam int K_W   = 18;
    localparam int M_W   = 9;
    localparam int A_W   = 4;

    typedef enum logic [1:0] {
        XS_IDLE    = 2'd0,
        XS_LOADING = 2'd1,
        XS_XFER    = 2'd2
    } xfer_state_e;
endpackage

// File: rtl/ssp_sync.sv
module ssp_sync #(
    parameter int          W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] level,
    output logic [W-1:0] rise
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic s1, s2, s3;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                s1 <= RST_VAL[i];
                s2 <= RST_VAL[i];
                s3 <= RST_VAL[i];
            end else begin
                s1 <= async_in[i];
                s2 <= s1;
                s3 <= s2;
            end
        end
        assign level[i] = s2;
        assign rise[i]  = s2 & ~s3;
    end
endmodule

// File: rtl/ssp_shifter.sv
module ssp_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift,
    input  logic         din,
    output logic [W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     q <= '0;
        else if (shift) q <= {q[W-2:0], din};
    end
endmodule

// File: rtl/ssp_xfer_fsm.sv
module ssp_xfer_fsm
    import synth_spi_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        window_open,
    input  logic        strobe_rise,
    output xfer_state_e state,
    output logic        commit
);
    xfer_state_e nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= XS_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            XS_IDLE:    if (strobe_rise)      nxt = XS_XFER;
                        else if (window_open) nxt = XS_LOADING;
            XS_LOADING: if (strobe_rise)      nxt = XS_XFER;
            XS_XFER:    if (strobe_rise)      nxt = XS_XFER;
                        else if (window_open) nxt = XS_LOADING;
                        else                  nxt = XS_IDLE;
            default:                          nxt = XS_IDLE;
        endcase
    end

    assign commit = (state == XS_XFER);
endmodule

// File: rtl/synth_serial_port.sv
module synth_serial_port
    import synth_spi_pkg::*;
#(
    parameter int P_PRI_W = PRI_W,
    parameter int P_ENH_W = ENH_W,
    parameter int P_K_W   = K_W,
    parameter int P_M_W   = M_W,
    parameter int P_A_W   = A_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ser_clk,
    input  logic               ser_data,
    input  logic               load_n,
    input  logic               enh_sel,
    input  logic               hop_wr,
    input  logic               direct_sel,
    input  logic [P_K_W-1:0]   par_k,
    input  logic [P_M_W-1:0]   par_m,
    input  logic [P_A_W-1:0]   par_a,
    input  logic               presc_en_n_i,
    output logic [P_K_W-1:0]   div_k,
    output logic [P_M_W-1:0]   div_m,
    output logic [P_A_W-1:0]   div_a,
    output logic [P_ENH_W-1:0] enh_q,
    output logic               presc_en_n_o
);
    localparam int M_LSB  = P_PRI_W - P_M_W;
    localparam int A_LSB  = M_LSB - P_A_W;
    localparam int KS_W   = A_LSB;
    localparam int NSYNC  = 5;
    // bit order: hop, enh_sel, load_n, data, sclk ; load_n idles high
    localparam logic [NSYNC-1:0] SYNC_RST = 5'b00100;

    logic [NSYNC-1:0] lvl, rise;
    logic             sclk_rise, data_s, load_s, load_rise, enh_s, hop_rise;
    logic             shift_en, strobe_rise, commit;
    logic             pri_shift, enh_shift;
    logic [P_PRI_W-1:0] pri_q, sec_q;
    xfer_state_e      state;

    ssp_sync #(.W(NSYNC), .RST_VAL(SYNC_RST)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .async_in({hop_wr, enh_sel, load_n, ser_data, ser_clk}),
        .level(lvl), .rise(rise)
    );

    assign sclk_rise   = rise[0];
    assign data_s      = lvl[1];
    assign load_s      = lvl[2];
    assign load_rise   = rise[2];
    assign enh_s       = lvl[3];
    assign hop_rise    = rise[4];
    assign shift_en    = ~load_s;
    assign strobe_rise = load_rise | hop_rise;
    assign pri_shift   = shift_en & sclk_rise & ~enh_s;
    assign enh_shift   = shift_en & sclk_rise &  enh_s;

    ssp_shifter #(.W(P_PRI_W)) u_pri (
        .clk(clk), .rst_n(rst_n), .shift(pri_shift), .din(data_s), .q(pri_q)
    );

    ssp_shifter #(.W(P_ENH_W)) u_enh (
        .clk(clk), .rst_n(rst_n), .shift(enh_shift), .din(data_s), .q(enh_q)
    );

    ssp_xfer_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .window_open(shift_en),
        .strobe_rise(strobe_rise), .state(state), .commit(commit)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      sec_q <= '0;
        else if (commit) sec_q <= pri_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_k        <= '0;
            div_m        <= '0;
            div_a        <= '0;
            presc_en_n_o <= 1'b0;
        end else begin
            presc_en_n_o <= presc_en_n_i;
            if (direct_sel) begin
                div_k <= par_k;
                div_m <= par_m;
                div_a <= par_a;
            end else begin
                div_k <= {{(P_K_W-KS_W){1'b0}}, sec_q[KS_W-1:0]};
                div_m <= sec_q[P_PRI_W-1:M_LSB];
                div_a <= sec_q[M_LSB-1:A_LSB];
            end
        end
    end
endmodule

// File: rtl/ssp_checker.sv
module ssp_checker
    import synth_spi_pkg::*;
#(
    parameter int P_PRI_W = PRI_W,
    parameter int P_ENH_W = ENH_W,
    parameter int P_K_W   = K_W,
    parameter int P_M_W   = M_W,
    parameter int P_A_W   = A_W
) (
    input logic               clk,
    input logic               rst_n,
    input logic               direct_sel,
    input logic [P_K_W-1:0]   par_k,
    input logic [P_M_W-1:0]   par_m,
    input logic [P_A_W-1:0]   par_a,
    input logic [P_K_W-1:0]   div_k,
    input logic [P_M_W-1:0]   div_m,
    input logic [P_A_W-1:0]   div_a,
    input logic [P_ENH_W-1:0] enh_q,
    input logic [P_PRI_W-1:0] sec_q,
    input logic               shift_en,
    input logic               strobe_rise,
    input xfer_state_e        state
);
    localparam int M_LSB = P_PRI_W - P_M_W;

    AST_DIRECT_PINS: assert property (@(posedge clk) disable iff (!rst_n)
        direct_sel |=> (div_k == $past(par_k) && div_m == $past(par_m) && div_a == $past(par_a))); // R7
    AST_SERIAL_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
        !direct_sel |=> (div_m == $past(sec_q[P_PRI_W-1:M_LSB]))); // R3
    AST_ENH_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(enh_q)); // R2
    AST_SEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state != XS_XFER) |=> $stable(sec_q)); // R5
    AST_EDGE_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_rise |=> (state == XS_XFER)); // R9
    AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        state inside {XS_IDLE, XS_LOADING, XS_XFER}); // R9
endmodule

bind synth_serial_port ssp_checker #(
    .P_PRI_W(P_PRI_W), .P_ENH_W(P_ENH_W), .P_K_W(P_K_W), .P_M_W(P_M_W), .P_A_W(P_A_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .direct_sel(direct_sel),
    .par_k(par_k), .par_m(par_m), .par_a(par_a),
    .div_k(div_k), .div_m(div_m), .div_a(div_a), .enh_q(enh_q),
    .sec_q(sec_q), .shift_en(shift_en), .strobe_rise(strobe_rise), .state(state)
);

// File: tb/tb_synth_serial_port.sv
module tb_synth_serial_port;
    logic clk = 1'b0, rst_n = 1'b0;
    logic ser_clk = 0, ser_data = 0, load_n = 1, enh_sel = 0, hop_wr = 0, direct_sel = 0;
    logic [17:0] par_k = '0;
    logic [8:0]  par_m = '0;
    logic [3:0]  par_a = '0;
    logic presc_en_n_i = 0;
    logic [17:0] div_k;
    logic [8:0]  div_m;
    logic [3:0]  div_a;
    logic [7:0]  enh_q;
    logic presc_en_n_o;

    int checks = 0, errors = 0;
    bit done = 0;
    logic [19:0] act_word = '0;
    logic [7:0]  exp_enh = '0;

    always #2 clk = ~clk;

    synth_serial_port dut (.*);

    function automatic logic [8:0]  f_m(logic [19:0] w); return w[19:11]; endfunction
    function automatic logic [3:0]  f_a(logic [19:0] w); return w[10:7]; endfunction
    function automatic logic [17:0] f_k(logic [19:0] w); return {11'b0, w[6:0]}; endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic chk_out(string req, logic [19:0] w);
        chk(req, {14'b0, div_k}, {14'b0, f_k(w)});
        chk(req, {23'b0, div_m}, {23'b0, f_m(w)});
        chk(req, {28'b0, div_a}, {28'b0, f_a(w)});
    endtask

    task automatic wait_n(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(logic [31:0] v, int n);
        for (int i = n - 1; i >= 0; i--) begin
            ser_data = v[i];
            wait_n(4);
            ser_clk = 1;
            wait_n(4);
            ser_clk = 0;
        end
        wait_n(6);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] w;
        void'($urandom(32'd4711));
        wait_n(3);
        rst_n = 1;
        wait_n(2);
        chk_out("R1", 20'h0);
        chk("R1", {24'b0, enh_q}, 32'h0);

        for (int it = 0; it < 6; it++) begin
            w = $urandom;
            load_n = 0; wait_n(4);
            send(w, 20);
            chk_out("R5", act_word);
            load_n = 1; wait_n(10);
            act_word = w[19:0];
            chk_out("R3", act_word);
        end

        w = $urandom;
        load_n = 0; wait_n(4);
        send(w, 24);
        load_n = 1; wait_n(10);
        act_word = w[19:0];
        chk_out("R3 overlong", act_word);

        enh_sel = 1; load_n = 0; wait_n(4);
        w = $urandom;
        send(w >> 5, 3);
        exp_enh = {exp_enh[4:0], w[7:5]};
        chk("R4 partial", {24'b0, enh_q}, {24'b0, exp_enh});
        send(w, 5);
        exp_enh = w[7:0];
        chk("R4", {24'b0, enh_q}, {24'b0, exp_enh});
        load_n = 1; wait_n(10);
        chk_out("R4 primary kept", act_word);

        send(32'hFFFFF, 8);
        chk("R2 enh", {24'b0, enh_q}, {24'b0, exp_enh});
        enh_sel = 0; wait_n(4);
        send(~{12'b0, act_word}, 20);
        hop_wr = 1; wait_n(6); hop_wr = 0; wait_n(8);
        chk_out("R2", act_word);

        w = $urandom;
        load_n = 0; wait_n(4);
        send(w, 20);
        hop_wr = 1; wait_n(10);
        act_word = w[19:0];
        chk_out("R6", act_word);

        w = $urandom;
        send(w, 20);
        chk_out("R9 level", act_word);
        hop_wr = 0; wait_n(4);
        hop_wr = 1; wait_n(10);
        act_word = w[19:0];
        chk_out("R9 edge", act_word);
        hop_wr = 0; load_n = 1; wait_n(10);
        chk_out("R9 load", act_word);

        for (int it = 0; it < 4; it++) begin
            logic [17:0] k; logic [8:0] m; logic [3:0] a;
            k = 18'($urandom); m = 9'($urandom); a = 4'($urandom);
            if (it == 3) begin k = '1; m = '1; a = '1; end
            par_k = k; par_m = m; par_a = a; direct_sel = 1;
            wait_n(1);
            chk("R7 k", {14'b0, div_k}, {14'b0, k});
            chk("R7 m", {23'b0, div_m}, {23'b0, m});
            chk("R7 a", {28'b0, div_a}, {28'b0, a});
        end
        direct_sel = 0; wait_n(1);
        chk_out("R7 back", act_word);

        presc_en_n_i = 1; wait_n(1);
        chk("R8 high", {31'b0, presc_en_n_o}, 32'h1);
        presc_en_n_i = 0; wait_n(1);
        chk("R8 low", {31'b0, presc_en_n_o}, 32'h0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule